// File: doc/BRIEF.md
# Debug Register Bank with Burst Engine

This block is the register file that a serial debug link talks to on a small 16-bit processor. The link decodes its own framing and turns it into single-register reads and writes on a request/response stream. Behind that stream sit the following registers:

- a read-only 32-bit identity word;
- the CPU control and status words;
- four words that set up memory and register-file transfers;
- a parameterised number of hardware-breakpoint sets, each with control, status and two address words.

Writing the start bit of the transfer control word arms a burst engine. After that, each access the host makes to the transfer data word moves one item to or from memory, or to or from the CPU register file. The transfer moves words or bytes, and the engine steps the pointer itself.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns its data one cycle later on `rsp_valid`/`rsp_data`, and the data is held there until `rsp_ready` is seen. While a response is waiting and `rsp_ready` is low, `req_ready` stays low, so the host is back-pressured. Writes produce no response. The memory port and the register-file port carry single-cycle strobes, with read data returned combinationally in the same cycle.

Top module: `dbg_regbank`

## Requirements
- R1: After reset, every writable register reads zero, `busy` is low, `rsp_valid` is low and `req_ready` is high.
- R2: The identity word is the device code (24 bits) above a 4-bit ROM address width, above a 4-bit RAM address width. Offset 1 returns bits 31:16 and offset 0 returns bits 15:0. Writes to either offset change nothing.
- R3: CPU control at offset 2 keeps only bits 6:3, so writing 0xFFFF reads back 0x0078. The stored value drives `cpu_ctl`. CPU status at offset 3 returns `cpu_status` and ignores writes.
- R4: Transfer control at offset 4 keeps bits 3:1 and reads bit 0 as zero. The bits mean: bit 0 = start, bit 1 = write (clear = read), bit 2 = register-file target (clear = memory), bit 3 = byte size (clear = word).
- R5: Transfer address (offset 5), transfer data (offset 6) and transfer count (offset 7) are fully writable 16-bit words.
- R6: Breakpoint set k sits at offsets 8+4k to 11+4k:
  - +0 is control and keeps bits 4:0;
  - +1 is status, returns the set's slice of `bp_status` and ignores writes;
  - +2 and +3 are full 16-bit addresses.
- R7: A started transfer performs count+1 accesses and then drops `busy`. Memory and register-file strobes occur only while `busy` is high.
- R8: A word memory transfer starts at the transfer address, steps by 2 and uses `mem_be`=11.
- R9: A register-file transfer starts at index address[RF_IW-1:0] and steps by 1. The size bit is ignored for this target.
- R10: A byte memory write steps by 1. An even address drives `mem_be`=01 and an odd address drives `mem_be`=10, with the byte copied into both lanes of `mem_wdata`.
- R11: A byte memory read returns the addressed byte zero-extended to 16 bits.
- R12: A read accepted in one cycle raises `rsp_valid` with its data in the next cycle. `rsp_valid` and `rsp_data` hold while `rsp_ready` is low, and `req_ready` is low during that time.
- R13: While a transfer runs, a new start is ignored. In write mode the transfer advances only on writes to the data word. In read mode it advances only on reads of the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 16 | Read data |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MAW | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_rdata | input | 16 | Memory read data, same cycle |
| rf_req | output | 1 | Register-file access strobe |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | RF_IW | Register index |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Register read data, same cycle |
| cpu_ctl | output | 16 | CPU control word |
| cpu_status | input | 16 | CPU status word |
| bp_status | input | NBRK*16 | Breakpoint status words |
| bp_ctl | output | NBRK*5 | Breakpoint control fields |
| bp_addr_a | output | NBRK*16 | First breakpoint addresses |
| bp_addr_b | output | NBRK*16 | Second breakpoint addresses |

## Verification
Register writes take effect at the accepting edge. A read issued on any later cycle therefore sees the new value. Read data appears on `rsp_data` in the cycle after the read is accepted. A memory or register-file strobe is driven combinationally in the very cycle the data-word access is accepted, so the bench's model stores it at that same edge. The bench drives every input at the falling edge and samples the response, `busy` and its memory model at the falling edge that follows the accepting edge. Each result is therefore read exactly one registered stage after its cause.

// File: rtl/dbgrb_pkg.sv
package dbgrb_pkg;
  // register offsets
  localparam int OFS_ID_LO    = 0;
  localparam int OFS_ID_HI    = 1;
  localparam int OFS_CPU_CTL  = 2;
  localparam int OFS_CPU_STAT = 3;
  localparam int OFS_XF_CTL   = 4;
  localparam int OFS_XF_ADDR  = 5;
  localparam int OFS_XF_DATA  = 6;
  localparam int OFS_XF_CNT   = 7;
  localparam int OFS_BP_BASE  = 8;
  localparam int BP_STRIDE    = 4;

  // writable-bit masks
  localparam logic [15:0] MASK_CPU_CTL = 16'h0078;
  localparam logic [15:0] MASK_XF_CTL  = 16'h000E;
  localparam int          BP_CTL_W     = 5;

  // transfer control bit positions
  localparam int XC_START = 0;
  localparam int XC_WRITE = 1;
  localparam int XC_REGS  = 2;
  localparam int XC_BYTE  = 3;

  typedef struct packed {
    logic bytes;
    logic regs;
    logic write;
  } xf_mode_t;
endpackage

// File: rtl/dbgrb_ctl_regs.sv
module dbgrb_ctl_regs
  import dbgrb_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          ld_data,
  input  logic [15:0]   ld_value,
  output logic [15:0]   cpu_ctl_q,
  output logic [15:0]   xf_ctl_q,
  output logic [15:0]   xf_addr_q,
  output logic [15:0]   xf_data_q,
  output logic [15:0]   xf_cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ctl_q <= '0;
      xf_ctl_q  <= '0;
      xf_addr_q <= '0;
      xf_data_q <= '0;
      xf_cnt_q  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          AW'(OFS_CPU_CTL): cpu_ctl_q <= wdata & MASK_CPU_CTL;
          AW'(OFS_XF_CTL):  xf_ctl_q  <= wdata & MASK_XF_CTL;
          AW'(OFS_XF_ADDR): xf_addr_q <= wdata;
          AW'(OFS_XF_DATA): xf_data_q <= wdata;
          AW'(OFS_XF_CNT):  xf_cnt_q  <= wdata;
          default: ;
        endcase
      end
      // a read-mode transfer leaves the last fetched item in the data word
      if (ld_data) xf_data_q <= ld_value;
    end
  end
endmodule

// File: rtl/dbgrb_bp_set.sv
module dbgrb_bp_set
  import dbgrb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          sel,
  input  logic [15:0]         wdata,
  input  logic [15:0]         status_in,
  output logic [15:0]         rdata,
  output logic [BP_CTL_W-1:0] ctl_q,
  output logic [15:0]         a_q,
  output logic [15:0]         b_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (wr) begin
      case (sel)
        2'd0: ctl_q <= wdata[BP_CTL_W-1:0];
        2'd2: a_q   <= wdata;
        2'd3: b_q   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = {{(16-BP_CTL_W){1'b0}}, ctl_q};
      2'd1:    rdata = status_in;
      2'd2:    rdata = a_q;
      default: rdata = b_q;
    endcase
  end
endmodule

// File: rtl/dbgrb_xfer.sv
module dbgrb_xfer
  import dbgrb_pkg::*;
#(
  parameter int MAW   = 16,
  parameter int RF_IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xf_mode_t         start_mode,
  input  logic [15:0]      count,
  input  logic [MAW-1:0]   base,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [15:0]      wdata,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [MAW-1:0]   mem_addr,
  output logic [15:0]      mem_wdata,
  output logic [1:0]       mem_be,
  input  logic [15:0]      mem_rdata,
  output logic             rf_req,
  output logic             rf_we,
  output logic [RF_IW-1:0] rf_idx,
  output logic [15:0]      rf_wdata,
  input  logic [15:0]      rf_rdata,
  output logic             rd_fire,
  output logic [15:0]      rd_word
);
  logic           busy_q;
  xf_mode_t       mode_q;
  logic [15:0]    left_q;
  logic [MAW-1:0] ptr_q;
  logic           step;
  logic [MAW-1:0] stride;
  logic [7:0]     sel_byte;

  assign busy    = busy_q;
  assign step    = busy_q && (mode_q.write ? data_wr : data_rd);
  assign rd_fire = step && !mode_q.write;
  assign stride  = (mode_q.regs || mode_q.bytes) ? MAW'(1) : MAW'(2);

  // memory side
  assign mem_req   = step && !mode_q.regs;
  assign mem_we    = mode_q.write;
  assign mem_addr  = ptr_q;
  assign mem_wdata = mode_q.bytes ? {wdata[7:0], wdata[7:0]} : wdata;
  assign mem_be    = !mode_q.bytes ? 2'b11 : (ptr_q[0] ? 2'b10 : 2'b01);

  // register-file side
  assign rf_req   = step && mode_q.regs;
  assign rf_we    = mode_q.write;
  assign rf_idx   = ptr_q[RF_IW-1:0];
  assign rf_wdata = wdata;

  assign sel_byte = ptr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  always_comb begin
    if (mode_q.regs)       rd_word = rf_rdata;
    else if (mode_q.bytes) rd_word = {8'h00, sel_byte};
    else                   rd_word = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= '0;
      left_q <= '0;
      ptr_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        mode_q <= start_mode;
        left_q <= count;
        ptr_q  <= base;
      end
    end else if (step) begin
      ptr_q <= ptr_q + stride;
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 16'd1;
    end
  end
endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
  import dbgrb_pkg::*;
#(
  parameter int          NBRK     = 4,
  parameter int          MAW      = 16,
  parameter int          RF_IW    = 4,
  parameter logic [23:0] DEV_CODE = 24'h5A1C37,
  parameter logic [3:0]  ROM_AW   = 4'd10,
  parameter logic [3:0]  RAM_AW   = 4'd9,
  localparam int         AW       = $clog2(OFS_BP_BASE + BP_STRIDE * NBRK)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [15:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [15:0]              rsp_data,
  output logic                     busy,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [MAW-1:0]           mem_addr,
  output logic [15:0]              mem_wdata,
  output logic [1:0]               mem_be,
  input  logic [15:0]              mem_rdata,
  output logic                     rf_req,
  output logic                     rf_we,
  output logic [RF_IW-1:0]         rf_idx,
  output logic [15:0]              rf_wdata,
  input  logic [15:0]              rf_rdata,
  output logic [15:0]              cpu_ctl,
  input  logic [15:0]              cpu_status,
  input  logic [NBRK*16-1:0]       bp_status,
  output logic [NBRK*BP_CTL_W-1:0] bp_ctl,
  output logic [NBRK*16-1:0]       bp_addr_a,
  output logic [NBRK*16-1:0]       bp_addr_b
);
  localparam int          KW      = (NBRK > 1) ? $clog2(NBRK) : 1;
  localparam logic [31:0] ID_WORD = {DEV_CODE, ROM_AW, RAM_AW};

  logic        acc, wr_acc, rd_acc;
  logic        rsp_valid_q;
  logic [15:0] rsp_data_q;
  logic [15:0] cpu_ctl_q, xf_ctl_q, xf_addr_q, xf_data_q, xf_cnt_q;
  logic        rd_fire;
  logic [15:0] rd_word;
  logic [15:0] rd_mux;
  logic        data_wr, data_rd, start;
  xf_mode_t    start_mode;

  // request/response handshake
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  assign data_wr    = wr_acc && (req_addr == AW'(OFS_XF_DATA));
  assign data_rd    = rd_acc && (req_addr == AW'(OFS_XF_DATA));
  assign start      = wr_acc && (req_addr == AW'(OFS_XF_CTL)) && req_wdata[XC_START];
  assign start_mode = '{bytes: req_wdata[XC_BYTE], regs: req_wdata[XC_REGS],
                        write: req_wdata[XC_WRITE]};

  dbgrb_ctl_regs #(.AW(AW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_acc),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .ld_data  (rd_fire),
    .ld_value (rd_word),
    .cpu_ctl_q(cpu_ctl_q),
    .xf_ctl_q (xf_ctl_q),
    .xf_addr_q(xf_addr_q),
    .xf_data_q(xf_data_q),
    .xf_cnt_q (xf_cnt_q)
  );
  assign cpu_ctl = cpu_ctl_q;

  dbgrb_xfer #(.MAW(MAW), .RF_IW(RF_IW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_mode(start_mode),
    .count     (xf_cnt_q),
    .base      (xf_addr_q[MAW-1:0]),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .wdata     (req_wdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_rdata (mem_rdata),
    .rf_req    (rf_req),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .rf_wdata  (rf_wdata),
    .rf_rdata  (rf_rdata),
    .rd_fire   (rd_fire),
    .rd_word   (rd_word)
  );

  // breakpoint sets
  logic [AW-1:0] bp_off;
  logic [AW-3:0] bp_k;
  logic          bp_hit;
  logic [15:0]   bp_rdata [NBRK];

  assign bp_off = req_addr - AW'(OFS_BP_BASE);
  assign bp_k   = bp_off[AW-1:2];
  assign bp_hit = (req_addr >= AW'(OFS_BP_BASE)) && (int'(bp_k) < NBRK);

  for (genvar k = 0; k < NBRK; k++) begin : g_bp
    dbgrb_bp_set u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_acc && bp_hit && (int'(bp_k) == k)),
      .sel      (bp_off[1:0]),
      .wdata    (req_wdata),
      .status_in(bp_status[k*16 +: 16]),
      .rdata    (bp_rdata[k]),
      .ctl_q    (bp_ctl[k*BP_CTL_W +: BP_CTL_W]),
      .a_q      (bp_addr_a[k*16 +: 16]),
      .b_q      (bp_addr_b[k*16 +: 16])
    );
  end

  // read selection
  always_comb begin
    rd_mux = '0;
    if (bp_hit) begin
      rd_mux = bp_rdata[bp_k[KW-1:0]];
    end else begin
      case (req_addr)
        AW'(OFS_ID_LO):    rd_mux = ID_WORD[15:0];
        AW'(OFS_ID_HI):    rd_mux = ID_WORD[31:16];
        AW'(OFS_CPU_CTL):  rd_mux = cpu_ctl_q;
        AW'(OFS_CPU_STAT): rd_mux = cpu_status;
        AW'(OFS_XF_CTL):   rd_mux = xf_ctl_q;
        AW'(OFS_XF_ADDR):  rd_mux = xf_addr_q;
        AW'(OFS_XF_DATA):  rd_mux = rd_fire ? rd_word : xf_data_q;
        AW'(OFS_XF_CNT):   rd_mux = xf_cnt_q;
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_regbank_chk.sv
module dbg_regbank_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [15:0]   req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [15:0]   rsp_data,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_be,
  input logic          rf_req
);
  assert_start_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready && req_write &&
                          req_addr == AW'(4) && req_wdata[0]));

  assert_strobe_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rf_req) |-> busy);

  assert_lane_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 2'b11 || $countones(mem_be) == 1));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  assert_ready_when_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

bind dbg_regbank dbg_regbank_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .rf_req   (rf_req)
);

// File: tb/test_dbg_regbank.sv
module test_dbg_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NBRK = 4;
  localparam logic [15:0] ID_LO_EXP = 16'h37A9;
  localparam logic [15:0] ID_HI_EXP = 16'h5A1C;

  typedef struct packed {
    logic [4:0]  a;
    logic [15:0] d;
    logic [15:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{5'd2,  16'hFFFF, 16'h0078, 4'd3},
    '{5'd2,  16'h0000, 16'h0000, 4'd3},
    '{5'd3,  16'hFFFF, 16'h0000, 4'd3},
    '{5'd4,  16'hFFFE, 16'h000E, 4'd4},
    '{5'd4,  16'h0000, 16'h0000, 4'd4},
    '{5'd5,  16'hFFFF, 16'hFFFF, 4'd5},
    '{5'd5,  16'h0000, 16'h0000, 4'd5},
    '{5'd6,  16'hFFFF, 16'hFFFF, 4'd5},
    '{5'd7,  16'hFFFF, 16'hFFFF, 4'd5},
    '{5'd7,  16'h0000, 16'h0000, 4'd5},
    '{5'd8,  16'hFFFF, 16'h001F, 4'd6},
    '{5'd9,  16'hFFFF, 16'h0000, 4'd6},
    '{5'd10, 16'hFFFF, 16'hFFFF, 4'd6},
    '{5'd11, 16'hFFFF, 16'hFFFF, 4'd6},
    '{5'd20, 16'hFFFF, 16'h001F, 4'd6},
    '{5'd23, 16'h1234, 16'h1234, 4'd6},
    '{5'd0,  16'hFFFF, ID_LO_EXP, 4'd2},
    '{5'd1,  16'h0000, ID_HI_EXP, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy;
  logic [15:0] rsp_data;
  logic mem_req, mem_we, rf_req, rf_we;
  logic [15:0] mem_addr, mem_wdata, rf_wdata, cpu_ctl;
  logic [1:0] mem_be;
  logic [3:0] rf_idx;
  logic [15:0] mem_rdata, rf_rdata;
  logic [NBRK*16-1:0] bp_status = '0;
  logic [NBRK*5-1:0] bp_ctl;
  logic [NBRK*16-1:0] bp_addr_a, bp_addr_b;

  logic [15:0] mem [256];
  logic [15:0] rf [16];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_regbank i_dbg_regbank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .cpu_ctl(cpu_ctl), .cpu_status(16'h0000), .bp_status(bp_status),
    .bp_ctl(bp_ctl), .bp_addr_a(bp_addr_a), .bp_addr_b(bp_addr_b)
  );

  // memory and register-file models
  assign mem_rdata = mem[mem_addr[8:1]];
  assign rf_rdata  = rf[rf_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
    end else begin
      if (mem_req && mem_we) begin
        if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
      end
      if (rf_req && rf_we) rf[rf_idx] <= rf_wdata;
    end
  end

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 16'hxxxx;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] wpat [5];
    wpat = '{16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0FED};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'h0000);
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'h0000);
    check("R1 req_ready", {15'd0, req_ready}, 16'h0001);
    check("R1 cpu_ctl", cpu_ctl, 16'h0000);
    rd(5'd5, v);  check("R1 addr", v, 16'h0000);
    rd(5'd10, v); check("R1 bp addr", v, 16'h0000);

    // table of write-then-read vectors
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, v);
      check(rname(VECS[i].rq), v, VECS[i].e);
    end

    // R3 control output follows the stored bits
    wr(5'd2, 16'hFFFF);
    check("R3 cpu_ctl pin", cpu_ctl, 16'h0078);
    check("R6 bp_ctl pin", {11'd0, bp_ctl[4*5-1:3*5]}, 16'h001F);

    // R8 word memory write transfer at 0x0200, count 4
    wr(5'd5, 16'h0200); wr(5'd7, 16'h0004); wr(5'd4, 16'h0003);
    check("R7 busy after start", {15'd0, busy}, 16'h0001);
    for (int i = 0; i < 5; i++) begin
      wr(5'd6, wpat[i]);
      check("R8 word write", mem[i], wpat[i]);
      if (i == 3) check("R7 busy before last", {15'd0, busy}, 16'h0001);
    end
    check("R7 busy after count+1", {15'd0, busy}, 16'h0000);
    check("R8 no overrun", mem[5], 16'h0000);

    // R8 word memory read transfer
    wr(5'd4, 16'h0001);
    for (int i = 0; i < 5; i++) begin
      rd(5'd6, v);
      check("R8 word read", v, wpat[i]);
    end
    check("R7 busy after read", {15'd0, busy}, 16'h0000);

    // R9 register-file transfer at index 5
    wr(5'd5, 16'h0005); wr(5'd4, 16'h0007);
    wr(5'd6, 16'hCBA9); wr(5'd6, 16'h8765); wr(5'd6, 16'h4321);
    wr(5'd6, 16'h0123); wr(5'd6, 16'h4567);
    check("R9 rf5", rf[5], 16'hCBA9);
    check("R9 rf7", rf[7], 16'h4321);
    check("R9 rf9", rf[9], 16'h4567);
    check("R9 rf10 untouched", rf[10], 16'h0000);
    wr(5'd4, 16'h0005);
    rd(5'd6, v); check("R9 rd5", v, 16'hCBA9);
    rd(5'd6, v); check("R9 rd6", v, 16'h8765);
    rd(5'd6, v); rd(5'd6, v);
    rd(5'd6, v); check("R9 rd9", v, 16'h4567);

    // R10 byte memory write transfer at 0x0200
    wr(5'd5, 16'h0200); wr(5'd4, 16'h000B);
    wr(5'd6, 16'h0091);
    check("R10 even lane", mem[0], 16'h1291);
    wr(5'd6, 16'h0082);
    check("R10 odd lane", mem[0], 16'h8291);
    wr(5'd6, 16'h0073); wr(5'd6, 16'h0064); wr(5'd6, 16'h0055);
    check("R10 word1", mem[1], 16'h6473);
    check("R10 word2", mem[2], 16'h9A55);

    // R11 byte read transfer
    wr(5'd4, 16'h0009);
    rd(5'd6, v); check("R11 byte0", v, 16'h0091);
    rd(5'd6, v); check("R11 byte1", v, 16'h0082);
    rd(5'd6, v); rd(5'd6, v);
    rd(5'd6, v); check("R11 byte4", v, 16'h0055);

    // R13 start ignored while running; reads do not advance a write transfer
    wr(5'd5, 16'h0210); wr(5'd7, 16'h0001); wr(5'd4, 16'h0003);
    wr(5'd5, 16'h0300); wr(5'd4, 16'h0001);
    rd(5'd6, v);
    check("R13 read no step busy", {15'd0, busy}, 16'h0001);
    wr(5'd6, 16'hAAAA); wr(5'd6, 16'hBBBB);
    check("R13 first", mem[8], 16'hAAAA);
    check("R13 second", mem[9], 16'hBBBB);
    check("R13 restart ignored", mem[8'h80], 16'h0000);
    check("R13 busy clear", {15'd0, busy}, 16'h0000);

    // R12 back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'd5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R12 held valid", {15'd0, rsp_valid}, 16'h0001);
      check("R12 held data", rsp_data, 16'h0300);
      check("R12 ready low", {15'd0, req_ready}, 16'h0000);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 drained", {15'd0, rsp_valid}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule